// File: doc/BRIEF.md
# Flash Controller Command Front End with Key Lock

This block is the register face of an on-chip flash controller. Software reaches it over a simple 32-bit register bus with three word registers: a key register, a control register and a status register. The control register comes out of reset locked. It opens only after two fixed key words are written to the key register in the right order. Any mistake in the key sequence leaves it shut until the next reset.

Once the control register is open, software selects an operation. The choices are an erase of one sector, an erase of one or both banks, or programming. Programming starts when a data write arrives on the flash-space write port while the program bit is set. Sectors of the second bank use a non-binary code in the sector field. A cycle counter stands in for the flash array and holds busy for a fixed time per operation. Faulty requests raise sticky error flags in the status register and never start the counter. Software clears each flag by writing one to its bit.

The decoded operation appears on the `op_*` outputs while busy is high. These outputs are zero when the block is idle.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset the control register (byte offset 0x4) reads 0x8000_0000, the status register (offset 0x8) reads 0, the key register (offset 0x0) reads 0, `busy` is 0 and `op_kind` is 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to offset 0x0 clears control bit 31. Writes to the control register while bit 31 is set change nothing and start nothing.
- R3: A wrong first key, a wrong second key, or any key write while already open leaves the control register locked until reset, even if the correct sequence follows.
- R4: A control write with bit 31 set relocks the register and starts nothing. A fresh two-key sequence opens it again.
- R5: Control fields read back as written: bit 0 program, bit 1 sector erase, bit 2 bank-0 mass erase, bit 15 bank-1 mass erase, bits 9:8 write size, bits 7:3 sector code. Bit 16 (start) always reads 0.
- R6: A start with only sector erase set erases sector n for n in 0..23. The code is n for n<12 and 0x10 | (n-12) for n≥12. `op_kind` reads 2 (0 idle, 1 program, 2 sector erase, 3 mass erase), `op_sector` reads n, and busy lasts ERASE_CYCLES cycles.
- R7: A sector erase whose code has its low four bits at 12 or above sets status bit 1 (operation error) and does not set busy.
- R8: A sector erase of a sector whose `wp_mask` bit is 1 sets status bit 4 and does not set busy. The same applies to a mass erase of a bank that holds any protected sector.
- R9: A start with bit 2 and/or bit 15 set (and no other operation bit) erases those banks. `op_kind` reads 3, `op_banks` reads {bank1, bank0}, and busy lasts ERASE_CYCLES cycles.
- R10: Status bit 7 (sequence error) is set by a start with no erase bit, by a start with sector erase together with a mass-erase bit, by a start with the program bit together with an erase bit, and by a flash write while the program bit is clear.
- R11: A flash write with program set takes three outcomes by write size. A size code of 3 sets status bit 6. An address that is not a multiple of 2^size sets status bit 5 with no busy. Any other address gives busy for PROG_CYCLES cycles, with `op_kind` 1 and `op_addr` holding the address.
- R12: Status bit 16 equals `busy`. While busy, control writes and flash writes are ignored.
- R13: Error flags stay set until a status write has a one in their bit. Other flags and busy are unaffected by that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset (0x0 key, 0x4 control, 0x8 status) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mem_wr | input | 1 | Flash-space data write strobe |
| mem_addr | input | MEM_AW | Flash-space write byte address |
| wp_mask | input | 24 | Per-sector write protection, 1 = protected |
| busy | output | 1 | Modelled flash operation in progress |
| op_kind | output | 2 | Running operation: 0 none, 1 program, 2 sector, 3 mass |
| op_sector | output | 5 | Linear index of the sector being erased |
| op_banks | output | 2 | Banks being mass erased {bank1, bank0} |
| op_addr | output | MEM_AW | Address being programmed |

## Verification
The hardest state to reach is a request that arrives while an operation is already running. The bench starts a sector erase and, in the very next cycle, writes a different start command and a flash write. It then confirms three things: the sector shown on the outputs does not change, the control readback keeps the first value, and the busy window still totals exactly ERASE_CYCLES. The permanently locked state is reached three ways, each with its own reset: a wrong key word, the keys in reverse order, and a repeated first key after opening. Each attempt is followed by a correct sequence that must not open the register.

// File: rtl/flash_fe_pkg.sv
`timescale 1ns/1ps
package flash_fe_pkg;

  localparam int SECT_PER_BANK = 12;
  localparam int NUM_SECT      = 2 * SECT_PER_BANK;
  localparam int SECT_W        = 5;

  localparam logic [31:0] UNLOCK_WORD_A = 32'h4567_0123;
  localparam logic [31:0] UNLOCK_WORD_B = 32'hCDEF_89AB;

  localparam logic [3:0] OFS_KEY  = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_MASS = 2'd3
  } op_kind_e;

  // Stored part of the control register.
  typedef struct packed {
    logic              prog;
    logic              ser;
    logic              mass0;
    logic              mass1;
    logic [SECT_W-1:0] snb;
    logic [1:0]        psize;
  } ctrl_state_t;

  // A control write as seen on the bus.
  typedef struct packed {
    ctrl_state_t st;
    logic        go;
    logic        lock_req;
  } ctrl_write_t;

  typedef struct packed {
    logic seq;
    logic par;
    logic align;
    logic wprot;
    logic oper;
  } err_vec_t;

  typedef struct packed {
    logic              valid;
    logic [SECT_W-1:0] index;
  } sect_dec_t;

  // Bit 4 of the code selects the second bank; the low nibble is the
  // sector within that bank and must stay below the bank size.
  function automatic sect_dec_t decode_sector(input logic [SECT_W-1:0] code);
    sect_dec_t r;
    r.valid = (code[3:0] < 4'(SECT_PER_BANK));
    r.index = code[4] ? (SECT_W'(code[3:0]) + SECT_W'(SECT_PER_BANK))
                      : SECT_W'(code[3:0]);
    return r;
  endfunction

  // Address must be a multiple of 2**psize bytes.
  function automatic logic addr_aligned(input logic [1:0] psize,
                                        input logic [2:0] low);
    logic ok;
    case (psize)
      2'd0:    ok = 1'b1;
      2'd1:    ok = (low[0] == 1'b0);
      2'd2:    ok = (low[1:0] == 2'b00);
      default: ok = (low == 3'b000);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/flash_fe_keylock.sv
`timescale 1ns/1ps
module flash_fe_keylock
  import flash_fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        open
);

  typedef enum logic [1:0] {
    KL_WAIT_A = 2'd0,
    KL_WAIT_B = 2'd1,
    KL_OPEN   = 2'd2,
    KL_DEAD   = 2'd3
  } kl_state_e;

  kl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      KL_WAIT_A: if (key_wr) state_d = (key_data == UNLOCK_WORD_A) ? KL_WAIT_B : KL_DEAD;
      KL_WAIT_B: if (key_wr) state_d = (key_data == UNLOCK_WORD_B) ? KL_OPEN : KL_DEAD;
      KL_OPEN: begin
        if (key_wr)      state_d = KL_DEAD;
        else if (relock) state_d = KL_WAIT_A;
      end
      default:           state_d = KL_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KL_WAIT_A;
    else        state_q <= state_d;
  end

  assign open = (state_q == KL_OPEN);

  // R3
  key_dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KL_DEAD) |=> (state_q == KL_DEAD));

  // R2
  unlock_after_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(key_wr && key_data == UNLOCK_WORD_B));

endmodule

// File: rtl/flash_fe_timer.sv
`timescale 1ns/1ps
module flash_fe_timer #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_erase,
  output logic busy
);

  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R12
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R6
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> busy);

endmodule

// File: rtl/flash_fe_status.sv
`timescale 1ns/1ps
module flash_fe_status
  import flash_fe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_vec_t err_set,
  input  logic     clr_wr,
  input  err_vec_t clr_mask,
  output err_vec_t err_q
);

  err_vec_t clr_eff;
  err_vec_t keep_prev;

  assign clr_eff   = clr_wr ? clr_mask : err_vec_t'('0);
  assign keep_prev = err_vec_t'(err_q & ~clr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_vec_t'(keep_prev | err_set);
  end

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(keep_prev)) == $past(keep_prev)));

  // R13
  err_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & ~$past(err_q) & ~$past(err_set)) == '0));

endmodule

// File: rtl/flash_fe_cmd.sv
`timescale 1ns/1ps
module flash_fe_cmd
  import flash_fe_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              busy,
  input  logic              ctrl_wr,
  input  ctrl_write_t       ctrl_in,
  input  logic              mem_wr,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [NUM_SECT-1:0] wp_mask,
  output ctrl_state_t       ctrl_q,
  output logic              relock,
  output logic              load,
  output logic              load_erase,
  output err_vec_t          err_set,
  output op_kind_e          op_kind_q,
  output logic [SECT_W-1:0] op_sector_q,
  output logic [1:0]        op_banks_q,
  output logic [MEM_AW-1:0] op_addr_q
);

  localparam int WP_EXT_W = 1 << SECT_W;

  logic                ctrl_accept;
  logic                go;
  logic                mem_go;
  logic                erase_any;
  logic                seq_bad;
  logic                bank_prot;
  logic [WP_EXT_W-1:0] wp_ext;
  sect_dec_t           dec;
  op_kind_e            nxt_kind;
  logic [SECT_W-1:0]   nxt_sector;
  logic [1:0]          nxt_banks;

  assign ctrl_accept = ctrl_wr && open && !busy;
  assign relock      = ctrl_accept && ctrl_in.lock_req;
  assign go          = ctrl_accept && ctrl_in.go && !ctrl_in.lock_req;
  assign mem_go      = mem_wr && open && !busy && !ctrl_wr;

  assign wp_ext    = WP_EXT_W'(wp_mask);
  assign dec       = decode_sector(ctrl_in.st.snb);
  assign erase_any = ctrl_in.st.ser | ctrl_in.st.mass0 | ctrl_in.st.mass1;
  assign seq_bad   = !erase_any
                   || (ctrl_in.st.ser && (ctrl_in.st.mass0 || ctrl_in.st.mass1))
                   || ctrl_in.st.prog;
  assign bank_prot = (ctrl_in.st.mass0 && (|wp_mask[SECT_PER_BANK-1:0]))
                   || (ctrl_in.st.mass1 && (|wp_mask[NUM_SECT-1:SECT_PER_BANK]));

  always_comb begin
    err_set    = '0;
    load       = 1'b0;
    load_erase = 1'b0;
    nxt_kind   = OP_NONE;
    nxt_sector = '0;
    nxt_banks  = '0;
    if (go) begin
      if (seq_bad) begin
        err_set.seq = 1'b1;
      end else if (ctrl_in.st.ser) begin
        if (!dec.valid)              err_set.oper  = 1'b1;
        else if (wp_ext[dec.index])  err_set.wprot = 1'b1;
        else begin
          load       = 1'b1;
          load_erase = 1'b1;
          nxt_kind   = OP_SECT;
          nxt_sector = dec.index;
        end
      end else if (bank_prot) begin
        err_set.wprot = 1'b1;
      end else begin
        load       = 1'b1;
        load_erase = 1'b1;
        nxt_kind   = OP_MASS;
        nxt_banks  = {ctrl_in.st.mass1, ctrl_in.st.mass0};
      end
    end else if (mem_go) begin
      if (!ctrl_q.prog)                                    err_set.seq   = 1'b1;
      else if (ctrl_q.psize == 2'd3)                       err_set.par   = 1'b1;
      else if (!addr_aligned(ctrl_q.psize, mem_addr[2:0])) err_set.align = 1'b1;
      else begin
        load     = 1'b1;
        nxt_kind = OP_PROG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      op_kind_q   <= OP_NONE;
      op_sector_q <= '0;
      op_banks_q  <= '0;
      op_addr_q   <= '0;
    end else begin
      if (ctrl_accept) ctrl_q <= ctrl_in.st;
      if (load) begin
        op_kind_q   <= nxt_kind;
        op_sector_q <= nxt_sector;
        op_banks_q  <= nxt_banks;
        op_addr_q   <= mem_addr;
      end
    end
  end

  // R11
  align_err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set.align || err_set.par) |-> !load);

  // R2
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(ctrl_q));

  // R6
  sector_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_kind_q == OP_SECT) |-> (op_sector_q < SECT_W'(NUM_SECT)));

  // R12
  busy_freezes_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_q));

endmodule

// File: rtl/flash_cmd_frontend.sv
`timescale 1ns/1ps
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int MEM_AW       = 20,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mem_wr,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [23:0]       wp_mask,
  output logic              busy,
  output logic [1:0]        op_kind,
  output logic [4:0]        op_sector,
  output logic [1:0]        op_banks,
  output logic [MEM_AW-1:0] op_addr
);

  logic              key_wr, ctrl_wr, stat_wr;
  logic              open, relock, load, load_erase;
  ctrl_write_t       ctrl_in;
  ctrl_state_t       ctrl_q;
  err_vec_t          err_set, err_q, clr_mask;
  op_kind_e          op_kind_q;
  logic [SECT_W-1:0] op_sector_q;
  logic [1:0]        op_banks_q;
  logic [MEM_AW-1:0] op_addr_q;

  assign key_wr  = bus_wr && (bus_addr == OFS_KEY);
  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign stat_wr = bus_wr && (bus_addr == OFS_STAT);

  assign ctrl_in.st.prog  = bus_wdata[0];
  assign ctrl_in.st.ser   = bus_wdata[1];
  assign ctrl_in.st.mass0 = bus_wdata[2];
  assign ctrl_in.st.snb   = bus_wdata[7:3];
  assign ctrl_in.st.psize = bus_wdata[9:8];
  assign ctrl_in.st.mass1 = bus_wdata[15];
  assign ctrl_in.go       = bus_wdata[16];
  assign ctrl_in.lock_req = bus_wdata[31];

  assign clr_mask.seq   = bus_wdata[7];
  assign clr_mask.par   = bus_wdata[6];
  assign clr_mask.align = bus_wdata[5];
  assign clr_mask.wprot = bus_wdata[4];
  assign clr_mask.oper  = bus_wdata[1];

  flash_fe_keylock u_keylock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .relock   (relock),
    .open     (open)
  );

  flash_fe_cmd #(.MEM_AW(MEM_AW)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .open        (open),
    .busy        (busy),
    .ctrl_wr     (ctrl_wr),
    .ctrl_in     (ctrl_in),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .wp_mask     (wp_mask),
    .ctrl_q      (ctrl_q),
    .relock      (relock),
    .load        (load),
    .load_erase  (load_erase),
    .err_set     (err_set),
    .op_kind_q   (op_kind_q),
    .op_sector_q (op_sector_q),
    .op_banks_q  (op_banks_q),
    .op_addr_q   (op_addr_q)
  );

  flash_fe_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_erase (load_erase),
    .busy       (busy)
  );

  flash_fe_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_set  (err_set),
    .clr_wr   (stat_wr),
    .clr_mask (clr_mask),
    .err_q    (err_q)
  );

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {!open, 15'b0, ctrl_q.mass1, 5'b0, ctrl_q.psize,
                             ctrl_q.snb, ctrl_q.mass0, ctrl_q.ser, ctrl_q.prog};
      OFS_STAT: bus_rdata = {15'b0, busy, 8'b0, err_q.seq, err_q.par, err_q.align,
                             err_q.wprot, 2'b0, err_q.oper, 1'b0};
      default:  bus_rdata = 32'h0;
    endcase
  end

  assign op_kind   = busy ? op_kind_q   : OP_NONE;
  assign op_sector = busy ? op_sector_q : '0;
  assign op_banks  = busy ? op_banks_q  : '0;
  assign op_addr   = busy ? op_addr_q   : '0;

  // R4
  relock_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !open);

endmodule

// File: tb/tb_flash_cmd_frontend.sv
`timescale 1ns/1ps
module tb_flash_cmd_frontend;

  localparam int AW  = 20;
  localparam int PCY = 3;
  localparam int ECY = 7;
  localparam logic [31:0] KA = 32'h4567_0123;
  localparam logic [31:0] KB = 32'hCDEF_89AB;
  localparam logic [31:0] GO = 32'h0001_0000;
  localparam logic [31:0] SE = 32'h0000_0002;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = 4'h0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          mem_wr = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [23:0]   wp_mask = '0;
  logic          busy;
  logic [1:0]    op_kind;
  logic [4:0]    op_sector;
  logic [1:0]    op_banks;
  logic [AW-1:0] op_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_frontend #(.MEM_AW(AW), .PROG_CYCLES(PCY), .ERASE_CYCLES(ECY)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .wp_mask(wp_mask), .busy(busy), .op_kind(op_kind),
    .op_sector(op_sector), .op_banks(op_banks), .op_addr(op_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic mwr(input logic [AW-1:0] a);
    mem_wr = 1'b1; mem_addr = a;
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(4'h0, KA);
    wr(4'h0, KB);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] sect_ctrl(input int s);
    int code;
    code = (s >= 12) ? (16 + s - 12) : s;
    return SE | (32'(code) << 3) | GO;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(4'h4, v); chk("R1 ctrl", v, 32'h8000_0000);
    rd(4'h8, v); chk("R1 status", v, 32'h0);
    rd(4'h0, v); chk("R1 key", v, 32'h0);
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 op_kind", {30'b0, op_kind}, 32'h0);

    // R2 locked writes ignored
    wr(4'h4, SE | GO);
    rd(4'h4, v); chk("R2 locked ctrl", v, 32'h8000_0000);
    chk("R2 locked busy", {31'b0, busy}, 32'h0);

    // R3 three ways into the dead state
    wr(4'h0, KB); unlock();
    rd(4'h4, v); chk("R3 reversed keys", v, 32'h8000_0000);
    do_reset();
    wr(4'h0, 32'h1234_5678); unlock();
    rd(4'h4, v); chk("R3 wrong key", v, 32'h8000_0000);
    do_reset();
    unlock(); wr(4'h0, KA);
    rd(4'h4, v); chk("R3 key while open", v, 32'h8000_0000);
    unlock();
    rd(4'h4, v); chk("R3 stays dead", v, 32'h8000_0000);
    do_reset();

    // R2 proper unlock
    unlock();
    rd(4'h4, v); chk("R2 open", v, 32'h0);

    // R5 readback of fields, start reads 0
    wr(4'h4, 32'h0000_8305);
    rd(4'h4, v); chk("R5 readback", v, 32'h0000_8305);
    wr(4'h4, 32'h0);

    // R6 sweep over every sector
    for (int s = 0; s < 24; s++) begin
      wr(4'h4, sect_ctrl(s));
      chk("R6 kind", {30'b0, op_kind}, 32'd2);
      chk("R6 sector", {27'b0, op_sector}, 32'(s));
      rd(4'h8, v); chk("R12 busy bit", v, 32'h0001_0000);
      rd(4'h4, v); chk("R5 sector readback", v, sect_ctrl(s) & ~GO);
      busy_len(n); chk("R6 busy length", 32'(n), 32'(ECY));
    end

    // R7 invalid codes in both banks
    for (int b = 0; b < 2; b++) begin
      for (int lo = 12; lo < 16; lo++) begin
        wr(4'h4, SE | (32'(b * 16 + lo) << 3) | GO);
        chk("R7 no busy", {31'b0, busy}, 32'h0);
        rd(4'h8, v); chk("R7 oper flag", v, 32'h2);
        wr(4'h8, 32'h2);
        rd(4'h8, v); chk("R13 cleared", v, 32'h0);
      end
    end

    // R8 write protection
    wp_mask = 24'h1 << 5;
    wr(4'h4, sect_ctrl(5));
    chk("R8 protected no busy", {31'b0, busy}, 32'h0);
    rd(4'h8, v); chk("R8 wprot flag", v, 32'h10);
    wr(4'h8, 32'h10);
    wr(4'h4, sect_ctrl(6));
    busy_len(n); chk("R8 unprotected erase", 32'(n), 32'(ECY));
    wr(4'h4, 32'h4 | GO);
    rd(4'h8, v); chk("R8 mass bank0 protected", v, 32'h10);
    wr(4'h8, 32'h10);

    // R9 mass erase
    wr(4'h4, 32'h8000 | GO);
    chk("R9 kind", {30'b0, op_kind}, 32'd3);
    chk("R9 banks", {30'b0, op_banks}, 32'd2);
    busy_len(n); chk("R9 busy length", 32'(n), 32'(ECY));
    wp_mask = '0;
    wr(4'h4, 32'h8004 | GO);
    chk("R9 both banks", {30'b0, op_banks}, 32'd3);
    busy_len(n);

    // R10 sequence errors
    wr(4'h4, GO);
    rd(4'h8, v); chk("R10 no op", v, 32'h80);
    wr(4'h8, 32'h80);
    wr(4'h4, SE | 32'h4 | GO);
    rd(4'h8, v); chk("R10 sector+mass", v, 32'h80);
    wr(4'h8, 32'h80);
    wr(4'h4, SE | 32'h1 | GO);
    chk("R10 prog+erase no busy", {31'b0, busy}, 32'h0);
    rd(4'h8, v); chk("R10 prog+erase", v, 32'h80);
    wr(4'h8, 32'h80);
    wr(4'h4, 32'h0);
    mwr(20'h00100);
    rd(4'h8, v); chk("R10 write without program", v, 32'h80);
    wr(4'h8, 32'h80);

    // R11 program sweep over size and low address bits
    for (int ps = 0; ps < 4; ps++) begin
      wr(4'h4, 32'h1 | (32'(ps) << 8));
      for (int lo = 0; lo < 8; lo++) begin
        mwr(AW'(32'h00100 + lo));
        if (ps == 3) begin
          rd(4'h8, v); chk("R11 size 3", v, 32'h40);
          wr(4'h8, 32'h40);
        end else if ((lo % (1 << ps)) == 0) begin
          chk("R11 kind", {30'b0, op_kind}, 32'd1);
          chk("R11 addr", 32'(op_addr), 32'h00100 + 32'(lo));
          busy_len(n); chk("R11 busy length", 32'(n), 32'(PCY));
        end else begin
          chk("R11 misalign no busy", {31'b0, busy}, 32'h0);
          rd(4'h8, v); chk("R11 align flag", v, 32'h20);
          wr(4'h8, 32'h20);
        end
      end
    end

    // R12 requests during busy are ignored
    wr(4'h4, sect_ctrl(2));
    wr(4'h4, sect_ctrl(9));
    mwr(20'h00200);
    chk("R12 sector unchanged", {27'b0, op_sector}, 32'd2);
    rd(4'h4, v); chk("R12 ctrl unchanged", v, sect_ctrl(2) & ~GO);
    busy_len(n); chk("R12 busy total", 32'(n + 2), 32'(ECY));
    rd(4'h8, v); chk("R12 no flags", v, 32'h0);

    // R13 partial clear
    wr(4'h4, GO);
    wr(4'h4, SE | (32'd13 << 3) | GO);
    rd(4'h8, v); chk("R13 two flags", v, 32'h82);
    wr(4'h8, 32'h80);
    rd(4'h8, v); chk("R13 one cleared", v, 32'h02);
    wr(4'h8, 32'h0001_0002);
    rd(4'h8, v); chk("R13 all cleared", v, 32'h0);

    // R4 relock and reopen
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, v); chk("R4 relocked", v, 32'h8000_0000);
    wr(4'h4, sect_ctrl(0));
    chk("R4 start ignored", {31'b0, busy}, 32'h0);
    unlock();
    rd(4'h4, v); chk("R4 reopened", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule